// File: doc/BRIEF.md
# RF Cavity Protection Interlock

This block is the fast hardware interlock beside the digital feedback loop of a superconducting RF cavity. Every clock it looks at the drive I/Q pair the controller is about to send out, the forward and reflected power estimates, the measured cavity voltage amplitude and the amplitude setpoint. It decides whether the cavity has to be protected. Two hazards are covered. The first is excessive drive power, which can crack the input coupler window or reflect destructive power into the amplifier. The second is a cavity quench, which disturbs the cryogenic plant.

Drive power is estimated as I² + Q². Quench detection changes with the loop state. With the loop open, reflected power is compared against a programmable fraction of forward power. With the loop closed, a trip occurs when the amplitude falls below 80 % of the setpoint, unless the cavity is being pre-tuned. Every trip sets a sticky fault bit, and any set fault bit holds the drive cut. An over-power fault also switches the setpoint output back to the stored original setpoint. The host clears each fault bit by writing one to it. All thresholds arrive as host-written register values.

Top module: `cavity_guard`

## Requirements
- R1: While reset is active and on the first cycle after it, `faults` is 0, `driveCut` and `refRestore` are low, and `refOut` equals `ampRef`.
- R2: Over-power fault is bit 0 of `faults`. It sets when driveI² + driveQ² (signed 16-bit operands, unsigned 32-bit sum) is greater than or equal to `powerLimit`. Equality trips; one below does not.
- R3: While bit 0 is set, `refRestore` is high and `refOut` equals `refOrig`. Otherwise `refOut` equals `ampRef`.
- R4: Open-loop quench fault is bit 1. It sets when `closedLoop` is 0 and `reflPower` is strictly greater than (`fwdPower` × `reflRatio`) >> 15, where `reflRatio` is unsigned Q1.15 (0x8000 = 1.0).
- R5: Closed-loop quench fault is bit 2. It sets when `closedLoop` is 1, `preTune` is 0 and `cavAmp` × 5 < `ampRef` × 4. Equality does not trip.
- R6: With `preTune` at 1, the closed-loop condition sets no fault.
- R7: The loop mode selects the criterion. In closed loop the reflected/forward compare sets nothing, and in open loop the amplitude compare sets nothing.
- R8: Fault bits stay set until the host pulses the matching `faultClear` bit. If a trip and a clear of the same bit fall on the same edge, the trip wins.
- R9: `driveCut` is high exactly when any fault bit is set.
- R10: A trip condition present on the inputs at clock edge k shows on `faults`, `driveCut` and `refRestore` after edge k+1. A clear sampled at edge k takes effect after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rstN | input | 1 | Active-low synchronous reset |
| driveI | input | 16 | Drive in-phase value, signed |
| driveQ | input | 16 | Drive quadrature value, signed |
| fwdPower | input | 32 | Forward power estimate, unsigned |
| reflPower | input | 32 | Reflected power estimate, unsigned |
| reflRatio | input | 16 | Open-loop reflected/forward ratio, unsigned Q1.15 |
| powerLimit | input | 32 | Drive power limit |
| cavAmp | input | 16 | Measured cavity voltage amplitude |
| ampRef | input | 16 | Current amplitude setpoint |
| refOrig | input | 16 | Stored original setpoint restored on over-power |
| closedLoop | input | 1 | 1 = feedback loop closed, 0 = open |
| preTune | input | 1 | 1 = cavity being pre-tuned |
| faultClear | input | 3 | Write-one-to-clear strobe per fault bit |
| faults | output | 3 | Latched faults: bit0 over-power, bit1 open-loop quench, bit2 closed-loop quench |
| driveCut | output | 1 | Cut incident drive power |
| refRestore | output | 1 | Setpoint is being forced to the original value |
| refOut | output | 16 | Setpoint to use downstream |

## Verification
The hardest situation to reach is a trip that arrives on the very edge where the host clears the same bit. Random stimulus only lines these two up by chance, so a directed step holds an over-power condition and pulses the clear at once. Exact-threshold cases are also unlikely to come up at random: power equal to the limit, amplitude at exactly 80 % and reflected power at exactly the ratio. Directed vectors pin each boundary and the value one past it. Pre-tune and loop-mode masking are covered the same way, by holding a collapsed amplitude or a large reflection while the mode flags change.

// File: rtl/cavity_guard_pkg.sv
package cavity_guard_pkg;
  localparam int NumFaults   = 3;
  localparam int FaultPower  = 0;
  localparam int FaultOpen   = 1;
  localparam int FaultClosed = 2;

  typedef struct packed {
    logic closedQuench;
    logic openQuench;
    logic overPower;
  } tripStrobes_t;
endpackage

// File: rtl/cavity_guard_dp.sv
module cavity_guard_dp
  import cavity_guard_pkg::*;
#(
  parameter int IqWidth    = 16,
  parameter int PwrWidth   = 32,
  parameter int AmpWidth   = 16,
  parameter int RatioWidth = 16,
  parameter int RatioFrac  = 15
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [IqWidth-1:0]  driveI,
  input  logic signed [IqWidth-1:0]  driveQ,
  input  logic [PwrWidth-1:0]        fwdPower,
  input  logic [PwrWidth-1:0]        reflPower,
  input  logic [RatioWidth-1:0]      reflRatio,
  input  logic [2*IqWidth-1:0]       powerLimit,
  input  logic [AmpWidth-1:0]        cavAmp,
  input  logic [AmpWidth-1:0]        ampRef,
  input  logic                       closedLoop,
  input  logic                       preTune,
  output tripStrobes_t               trip
);
  localparam int SqWidth     = 2 * IqWidth;
  localparam int ProdWidth   = PwrWidth + RatioWidth;
  localparam int ScaledWidth = ProdWidth - RatioFrac;
  localparam int AmpScWidth  = AmpWidth + 3;

  logic signed [SqWidth-1:0] sqI, sqQ;
  logic [SqWidth-1:0]        sumSq;
  logic [ProdWidth-1:0]      fwdProd;

  logic                   validQ;
  logic [SqWidth-1:0]     pwrQ, limitQ;
  logic [PwrWidth-1:0]    reflQ;
  logic [ScaledWidth-1:0] fwdScQ;
  logic [AmpScWidth-1:0]  ampX5Q, refX4Q;
  logic                   closedQ, preTuneQ;

  always_comb begin
    sqI     = driveI * driveI;
    sqQ     = driveQ * driveQ;
    sumSq   = $unsigned(sqI) + $unsigned(sqQ);
    fwdProd = ProdWidth'(fwdPower) * ProdWidth'(reflRatio);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      pwrQ     <= '0;
      limitQ   <= '0;
      reflQ    <= '0;
      fwdScQ   <= '0;
      ampX5Q   <= '0;
      refX4Q   <= '0;
      closedQ  <= 1'b0;
      preTuneQ <= 1'b0;
    end else begin
      validQ   <= 1'b1;
      pwrQ     <= sumSq;
      limitQ   <= powerLimit;
      reflQ    <= reflPower;
      fwdScQ   <= ScaledWidth'(fwdProd >> RatioFrac);
      ampX5Q   <= AmpScWidth'(cavAmp) + (AmpScWidth'(cavAmp) << 2);
      refX4Q   <= AmpScWidth'(ampRef) << 2;
      closedQ  <= closedLoop;
      preTuneQ <= preTune;
    end
  end

  always_comb begin
    trip.overPower    = validQ && (pwrQ >= limitQ);
    trip.openQuench   = validQ && !closedQ && (ScaledWidth'(reflQ) > fwdScQ);
    trip.closedQuench = validQ && closedQ && !preTuneQ && (ampX5Q < refX4Q);
  end

  // R2: a sum of two squares of signed operands never exceeds 2^(SqWidth-1)
  assert_sq_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> (pwrQ <= (SqWidth'(1) << (SqWidth - 1))));
endmodule

// File: rtl/cavity_guard_ctl.sv
module cavity_guard_ctl
  import cavity_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  tripStrobes_t         trip,
  input  logic [NumFaults-1:0] faultClear,
  output logic [NumFaults-1:0] faults,
  output logic                 driveCut,
  output logic                 refRestore
);
  logic [NumFaults-1:0] tripVec;
  logic [NumFaults-1:0] faultQ;

  always_comb begin
    tripVec              = '0;
    tripVec[FaultPower]  = trip.overPower;
    tripVec[FaultOpen]   = trip.openQuench;
    tripVec[FaultClosed] = trip.closedQuench;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ <= '0;
    end else begin
      for (int k = 0; k < NumFaults; k++) begin
        if (tripVec[k])         faultQ[k] <= 1'b1;
        else if (faultClear[k]) faultQ[k] <= 1'b0;
      end
    end
  end

  assign faults     = faultQ;
  assign driveCut   = |faultQ;
  assign refRestore = faultQ[FaultPower];

  for (genvar g = 0; g < NumFaults; g++) begin : g_faultChk
    // R8: a set bit holds until its clear strobe
    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      (faultQ[g] && !faultClear[g]) |=> faultQ[g]);
    // R10: a trip strobe sets its bit on the next edge, even against a clear
    assert_trip_sets_R10: assert property (@(posedge clk) disable iff (!rstN)
      tripVec[g] |=> faultQ[g]);
  end

  // R9: no fault appears without a trip strobe
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ == '0 && tripVec == '0) |=> (faultQ == '0));
endmodule

// File: rtl/cavity_guard.sv
module cavity_guard
  import cavity_guard_pkg::*;
#(
  parameter int IqWidth    = 16,
  parameter int PwrWidth   = 32,
  parameter int AmpWidth   = 16,
  parameter int RatioWidth = 16,
  parameter int RatioFrac  = 15
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic signed [IqWidth-1:0] driveI,
  input  logic signed [IqWidth-1:0] driveQ,
  input  logic [PwrWidth-1:0]       fwdPower,
  input  logic [PwrWidth-1:0]       reflPower,
  input  logic [RatioWidth-1:0]     reflRatio,
  input  logic [2*IqWidth-1:0]      powerLimit,
  input  logic [AmpWidth-1:0]       cavAmp,
  input  logic [AmpWidth-1:0]       ampRef,
  input  logic [AmpWidth-1:0]       refOrig,
  input  logic                      closedLoop,
  input  logic                      preTune,
  input  logic [NumFaults-1:0]      faultClear,
  output logic [NumFaults-1:0]      faults,
  output logic                      driveCut,
  output logic                      refRestore,
  output logic [AmpWidth-1:0]       refOut
);
  tripStrobes_t trip;

  cavity_guard_dp #(
    .IqWidth(IqWidth), .PwrWidth(PwrWidth), .AmpWidth(AmpWidth),
    .RatioWidth(RatioWidth), .RatioFrac(RatioFrac)
  ) dp_i (
    .clk(clk), .rstN(rstN), .driveI(driveI), .driveQ(driveQ),
    .fwdPower(fwdPower), .reflPower(reflPower), .reflRatio(reflRatio),
    .powerLimit(powerLimit), .cavAmp(cavAmp), .ampRef(ampRef),
    .closedLoop(closedLoop), .preTune(preTune), .trip(trip)
  );

  cavity_guard_ctl ctl_i (
    .clk(clk), .rstN(rstN), .trip(trip), .faultClear(faultClear),
    .faults(faults), .driveCut(driveCut), .refRestore(refRestore)
  );

  assign refOut = refRestore ? refOrig : ampRef;

  // R6: a closed-loop quench fault only rises from closed-loop, non-pre-tune inputs
  assert_pretune_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faults[FaultClosed]) |-> ($past(closedLoop, 2) && !$past(preTune, 2)));
endmodule

// File: tb/cavity_guard_tb_top.sv
module cavity_guard_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [15:0] driveI = '0, driveQ = '0;
  logic [31:0] fwdPower = '0, reflPower = '0, powerLimit = '1;
  logic [15:0] reflRatio = 16'h8000, cavAmp = '0, ampRef = '0, refOrig = 16'h1234;
  logic closedLoop = 1'b1, preTune = 1'b0;
  logic [2:0] faultClear = '0;
  logic [2:0] faults;
  logic driveCut, refRestore;
  logic [15:0] refOut;

  int vectors = 0, miscompares = 0;
  logic [2:0] expFault = '0, pendTrip = '0;
  string curTag = "R1";
  int unsigned seedVal;

  always #2.5 clk = ~clk;

  cavity_guard dut_i (
    .clk(clk), .rstN(rstN), .driveI(driveI), .driveQ(driveQ),
    .fwdPower(fwdPower), .reflPower(reflPower), .reflRatio(reflRatio),
    .powerLimit(powerLimit), .cavAmp(cavAmp), .ampRef(ampRef), .refOrig(refOrig),
    .closedLoop(closedLoop), .preTune(preTune), .faultClear(faultClear),
    .faults(faults), .driveCut(driveCut), .refRestore(refRestore), .refOut(refOut)
  );

  function automatic logic [2:0] calcTrip();
    logic [2:0] t;
    longint pI, pQ;
    logic [63:0] scaled;
    pI = longint'(driveI) * longint'(driveI);
    pQ = longint'(driveQ) * longint'(driveQ);
    t[0] = (pI + pQ) >= longint'({32'b0, powerLimit});
    scaled = ({32'b0, fwdPower} * {48'b0, reflRatio}) >> 15;
    t[1] = !closedLoop && ({32'b0, reflPower} > scaled);
    t[2] = closedLoop && !preTune && ((int'(cavAmp) * 5) < (int'(ampRef) * 4));
    return t;
  endfunction

  task automatic checkOut();
    logic [15:0] expRef;
    expRef = expFault[0] ? refOrig : ampRef;
    vectors++;
    if (faults !== expFault || driveCut !== (|expFault) ||
        refRestore !== expFault[0] || refOut !== expRef) begin
      miscompares++;
      $display("FAIL %s: faults=%b cut=%b rst=%b ref=%h expected faults=%b cut=%b rst=%b ref=%h",
               curTag, faults, driveCut, refRestore, refOut,
               expFault, |expFault, expFault[0], expRef);
    end
  endtask

  // inputs are set beforehand; one clock edge, model update, check at negedge
  task automatic step();
    logic [2:0] nf;
    @(posedge clk);
    nf = pendTrip | (expFault & ~faultClear);
    pendTrip = calcTrip();
    expFault = nf;
    @(negedge clk);
    checkOut();
  endtask

  task automatic safeInputs();
    driveI = 0; driveQ = 0; powerLimit = '1; fwdPower = 0; reflPower = 0;
    reflRatio = 16'h8000; cavAmp = 100; ampRef = 100; closedLoop = 1; preTune = 0;
  endtask

  task automatic clearAll();
    safeInputs();
    faultClear = 3'b111; step(); step();
    faultClear = 3'b000; step();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, expected completion");
    finishRun();
  end

  initial begin
    seedVal = $urandom(32'd20240611);
    safeInputs();
    // R1: reset state
    curTag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); checkOut();
    rstN = 1'b1;
    step();

    // R2: equality trips (9 + 16 = 25)
    clearAll();
    curTag = "R2";
    driveI = 3; driveQ = -4; powerLimit = 25; step(); step();
    // R3: restore while over-power latched
    curTag = "R3";
    ampRef = 16'h0777; safeInputs(); ampRef = 16'h0777; step();
    // R2: one below does not trip
    clearAll();
    curTag = "R2";
    driveI = 3; driveQ = 4; powerLimit = 26; step(); step();
    // R2: extreme negative operands
    driveI = -32768; driveQ = -32768; powerLimit = 32'h8000_0000; step(); step();

    // R5: 80 % boundary
    clearAll();
    curTag = "R5";
    cavAmp = 4; ampRef = 5; step(); step();
    cavAmp = 3; step(); step();
    // R6: pre-tune masks collapsed amplitude
    clearAll();
    curTag = "R6";
    preTune = 1; cavAmp = 0; ampRef = 16'hffff; step(); step(); step();

    // R4: open loop, ratio 1.0, equality then one more
    clearAll();
    curTag = "R4";
    closedLoop = 0; fwdPower = 1000; reflPower = 1000; step(); step();
    reflPower = 1001; step(); step();
    // R7: open loop ignores collapsed amplitude
    clearAll();
    curTag = "R7";
    closedLoop = 0; cavAmp = 0; ampRef = 16'hffff; step(); step();
    // R7: closed loop ignores large reflection
    closedLoop = 1; cavAmp = 100; ampRef = 100; reflPower = '1; fwdPower = 1; step(); step();

    // R8: trip and clear on the same edge, trip wins
    clearAll();
    curTag = "R8";
    driveI = 100; powerLimit = 1; step(); step();
    faultClear = 3'b001; step(); step();
    // R10/R9: clear takes effect once trip gone
    curTag = "R10";
    safeInputs(); faultClear = 3'b001; step(); step();
    faultClear = 3'b000; step();

    // R9: random mixture of all criteria
    curTag = "R9";
    for (int n = 0; n < 4000; n++) begin
      driveI = 16'($urandom); driveQ = 16'($urandom);
      powerLimit = $urandom >> ($urandom % 4);
      fwdPower = $urandom >> ($urandom % 8);
      reflPower = $urandom >> ($urandom % 8);
      reflRatio = 16'($urandom);
      cavAmp = 16'($urandom); ampRef = 16'($urandom);
      closedLoop = 1'($urandom); preTune = 1'($urandom);
      faultClear = (($urandom % 3) == 0) ? 3'($urandom) : 3'b000;
      step();
    end
    finishRun();
  end
endmodule